// File: doc/BRIEF.md
# Bubble-Tolerant Multi-Edge Delay-Line Encoder

This block turns one wide snapshot of a tapped delay line into a binary bin number. The snapshot comes from a line that carries several edges at once, so it is not a clean thermometer code. It may also hold stray single-bit errors, called bubbles. A strobe loads the snapshot into an input register. Combinational logic then cleans the bits with a three-bit majority window and finds the lowest 1-to-0 step. A binary tree of pairwise merges turns that step into an index. The result goes into an output register one clock later.

The tree has one leaf for each possible code value. Each merge passes up a "step seen" flag and the position bits found so far. When both halves hold a step, the half with the lower indices wins. The whole path from input register to output register is plain logic with no multi-cycle path. If no step exists, the code reads zero and a separate flag says so.

Top module: `wu_edge_encoder`

## Requirements
- R1: When `strobe` is high at a rising edge, `snapshot` is captured there, and `valid` is high for exactly the one cycle that follows the next rising edge.
- R2: `valid` is never high unless `strobe` was high two rising edges earlier. In particular it drops after one cycle when strobes are not repeated.
- R3: `bin_code` and `no_hit` change only with a `valid` pulse. Changing `snapshot` with `strobe` low leaves them unchanged.
- R4: Each bit is cleaned to the majority of itself and its two neighbours. Positions below bit 0 and above the top bit count as 0. For example, a lone 1 at bit 0 is removed, and bits 0 and 1 both set survive.
- R5: The reported index is the lowest i where cleaned bit i is 1 and cleaned bit i+1 is 0. The bit above the top counts as 0, so a run reaching the top bit reports IN_W-1.
- R6: A snapshot with two or more separate runs of ones reports the end of the lowest run.
- R7: With no 1-to-0 step after cleaning, `bin_code` is 0 and `no_hit` is 1 in the result cycle. Otherwise `no_hit` is 0.
- R8: One flipped bit with at least two correct bits of its original value on each side does not change the reported index.
- R9: After reset, `valid`, `no_hit` and `bin_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Capture request for `snapshot` |
| snapshot | input | IN_W | Raw delay-line taps |
| valid | output | 1 | One-cycle result pulse |
| no_hit | output | 1 | No transition found in the last result |
| bin_code | output | OUT_W | Index of the lowest transition |

## Verification
A snapshot strobed at edge k appears on `bin_code` and `no_hit` after edge k+1, along with a one-cycle `valid` pulse. Each bench transaction drives on a falling edge and removes the strobe on the next falling edge. It samples the result on the falling edge after that, when `valid` must be high. One falling edge later, `valid` must be low again. The hold check changes `snapshot` without a strobe, waits several cycles, and reads the ports again.

// File: rtl/wu_edge_encoder.sv
module wu_edge_encoder #(
  parameter int IN_W  = 276,
  parameter int OUT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [IN_W-1:0]  snapshot,
  output logic             valid,
  output logic             no_hit,
  output logic [OUT_W-1:0] bin_code
);
  localparam int LEAVES = 1 << OUT_W;

  logic [IN_W-1:0]  snap_q;
  logic             pend_q;
  logic [IN_W+1:0]  ext;
  logic [IN_W-1:0]  clean;
  logic [IN_W:0]    clean_x;
  logic [IN_W-1:0]  step;
  logic [2*LEAVES-1:1] seen;
  logic [OUT_W-1:0] pos [1:2*LEAVES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snap_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= strobe;
      if (strobe) snap_q <= snapshot;
    end

  assign ext     = {1'b0, snap_q, 1'b0};
  assign clean_x = {1'b0, clean};

  for (genvar i = 0; i < IN_W; i++) begin : g_clean
    assign clean[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
  end

  assign step = clean & ~clean_x[IN_W:1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    assign pos[LEAVES+i] = '0;
    if (i < IN_W) begin : g_real
      assign seen[LEAVES+i] = step[i];
    end else begin : g_pad
      assign seen[LEAVES+i] = 1'b0;
    end
  end

  for (genvar h = 1; h <= OUT_W; h++) begin : g_lvl
    for (genvar j = 0; j < (LEAVES >> h); j++) begin : g_node
      localparam int K = (LEAVES >> h) + j;
      assign seen[K] = seen[2*K] | seen[2*K+1];
      assign pos[K]  = seen[2*K] ? pos[2*K]
                                 : (pos[2*K+1] | (OUT_W'(1) << (h-1)));
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid    <= 1'b0;
      no_hit   <= 1'b0;
      bin_code <= '0;
    end else begin
      valid <= pend_q;
      if (pend_q) begin
        no_hit   <= ~seen[1];
        bin_code <= seen[1] ? pos[1] : '0;
      end
    end

  a_r1_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ##1 valid);
  a_r2_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(strobe, 2));
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(bin_code) && $stable(no_hit)));
  a_r7_nohit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    no_hit |-> (bin_code == '0));
  a_r5_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !no_hit |-> (int'(bin_code) < IN_W));
endmodule

// File: tb/wu_edge_encoder_bench.sv
module wu_edge_encoder_bench;
  localparam int IN_W  = 276;
  localparam int OUT_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             strobe = 1'b0;
  logic [IN_W-1:0]  snapshot = '0;
  logic             valid, no_hit;
  logic [OUT_W-1:0] bin_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wu_edge_encoder #(.IN_W(IN_W), .OUT_W(OUT_W)) u_wu_edge_encoder (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .snapshot(snapshot),
    .valid(valid), .no_hit(no_hit), .bin_code(bin_code));

  // run1 lo,hi ; run2 lo,hi ; flipped bit (-1 none) ; expected code ; expected no_hit
  localparam int NV = 10;
  localparam int TBL [NV][7] = '{
    '{0, 99, -1, -2, -1, 99, 0},    // R5 plain run
    '{0, 99, 150, 200, -1, 99, 0},  // R6 two runs
    '{0, 99, -1, -2, 50, 99, 0},    // R8 zero bubble inside ones
    '{10, 40, -1, -2, 120, 40, 0},  // R8 one bubble inside zeros
    '{200, 275, -1, -2, -1, 275, 0},// R5 run reaches top bit
    '{-1, -2, -1, -2, 30, 0, 1},    // R7 lone bubble only
    '{0, 0, -1, -2, -1, 0, 1},      // R4 lone 1 at bit 0 removed
    '{0, 1, -1, -2, -1, 1, 0},      // R4 two bits at bottom survive
    '{5, 7, 20, 30, -1, 7, 0},      // R6 short lowest run
    '{30, 80, 120, 275, 100, 80, 0} // R6 R8 run to top plus bubble
  };

  function automatic logic [IN_W-1:0] mk(int alo, int ahi, int blo, int bhi, int flip);
    logic [IN_W-1:0] v = '0;
    for (int i = 0; i < IN_W; i++)
      if ((i >= alo && i <= ahi) || (i >= blo && i <= bhi)) v[i] = 1'b1;
    if (flip >= 0) v[flip] = ~v[flip];
    return v;
  endfunction

  function automatic int ref_code(logic [IN_W-1:0] v);
    logic [IN_W-1:0] c;
    for (int i = 0; i < IN_W; i++) begin
      int s = int'(v[i]) + ((i > 0) ? int'(v[i-1]) : 0) + ((i < IN_W-1) ? int'(v[i+1]) : 0);
      c[i] = (s >= 2);
    end
    for (int i = 0; i < IN_W; i++)
      if (c[i] && (i == IN_W-1 || !c[i+1])) return i;
    return -1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(logic [IN_W-1:0] v, int exp, string req);
    @(negedge clk); snapshot = v; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    check({req, " R1 valid pulse"}, int'(valid), 0);
    @(negedge clk);
    check({req, " R1 valid"}, int'(valid), 1);
    check({req, " code"}, int'(bin_code), (exp < 0) ? 0 : exp);
    check({req, " R7 no_hit"}, int'(no_hit), (exp < 0) ? 1 : 0);
    @(negedge clk);
    check({req, " R2 valid drop"}, int'(valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 valid", int'(valid), 0);
    check("R9 no_hit", int'(no_hit), 0);
    check("R9 code", int'(bin_code), 0);
    rst_n = 1'b1;

    for (int t = 0; t < NV; t++)
      run(mk(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3], TBL[t][4]),
          TBL[t][6] ? -1 : TBL[t][5], $sformatf("table%0d", t));

    // R3: change input without strobe, outputs hold
    run(mk(0, 60, -1, -2, -1), 60, "R3 setup");
    @(negedge clk); snapshot = mk(0, 200, -1, -2, -1);
    repeat (5) @(negedge clk);
    check("R3 hold code", int'(bin_code), 60);
    check("R3 hold no_hit", int'(no_hit), 0);
    check("R3 no valid", int'(valid), 0);

    // R8: bubble two or more bits from the step leaves result unchanged
    run(mk(0, 70, -1, -2, 68), 70, "R8 near ones");
    run(mk(0, 70, -1, -2, 73), 70, "R8 near zeros");

    // R6 R8: random two-run codes with one bubble versus reference
    for (int n = 0; n < 150; n++) begin
      int alo = $urandom_range(0, 100);
      int ahi = alo + $urandom_range(2, 60);
      int blo = ahi + $urandom_range(3, 40);
      int bhi = blo + $urandom_range(2, 60);
      int fl  = $urandom_range(0, IN_W-1);
      logic [IN_W-1:0] v = mk(alo, ahi, blo, (bhi > IN_W-1) ? IN_W-1 : bhi, fl);
      run(v, ref_code(v), "R6 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule